// File: doc/BRIEF.md
# Three-Slot Asymmetric Decode Group Allocator

This block sits between an in-order instruction queue and three decoders that are not all alike. Each cycle it looks at a window of up to three instruction descriptors, the oldest in entry 0, and forms one decode group from them. The group has one general slot, slot 0, and two restricted slots, slots 1 and 2. Each descriptor carries a uop class: simple (one uop), multi (two to four uops) or microcoded (a long sequence whose length in cycles comes with the descriptor).

Only slot 0 takes multi or microcoded instructions. A restricted slot can be filled only when slot 0 is filled in the same cycle and the slot before it is filled too. This gives the 4-1-1 pattern: at most one wide instruction at the head of a group, followed by simple ones. Allocation stays in program order. The first entry that cannot go into the next free slot closes the group, and that entry waits for a later cycle. The block reports how many leading window entries it took (`win_take`), which slot positions are valid in the registered output, the tag of each slot, and the total uops emitted that cycle.

A microcoded instruction takes slot 0 alone and holds it for its whole sequence. The controller has two states. In `ST_GROUP` it forms a new group every cycle. In `ST_UCODE` a microcoded instruction is still sequencing and nothing new is taken.

- Transition `GROUP_TO_UCODE`: a microcoded entry with length greater than 1 is accepted.
- Self-loop `GROUP_HOLD`: every other case in `ST_GROUP`, including a microcoded entry of length 0 or 1.
- Self-loop `UCODE_STEP`: a sequencing cycle that is not the last one, or any stalled cycle.
- Transition `UCODE_TO_GROUP`: the final sequencing cycle.

The downstream `stall` input freezes the block. While it is high nothing is taken, the outputs are cleared and the sequencing count does not advance.

Top module: `dec_alloc3`

## Requirements
- R1: After reset, `slot_vld` is 0, `uop_sum` is 0, and with `stall` low `in_ready` is 1.
- R2: When `in_ready` is 1 and `win_vld[0]` is 1, entry 0 is taken into slot 0 in that cycle (`win_take` ≥ 1). On the next cycle `slot_vld[0]` is 1.
- R3: Class codes are 00 simple, 01 multi, 1x microcoded. Slot k (k ≥ 1) is filled only when slot k-1 is filled, entry 0 is not microcoded, and entry k is valid and simple. The first entry that fails this closes the group, and later entries are ignored. `win_take` equals the number of slots filled.
- R4: No restricted slot is filled when slot 0 is not filled. If entry 0 is invalid, `win_take` is 0 and no slot is valid, whatever the other entries hold.
- R5: For a group without a microcoded entry, `uop_sum` is the slot 0 uops plus one for each filled restricted slot. A simple entry counts as 1 whatever its 3-bit count field holds. A multi entry counts its field clamped into 2..4. The sum never exceeds 6.
- R6: A microcoded entry is taken alone (`win_take` = 1). It then shows on the output as slot 0 only, with `uop_sum` = 4, for L non-stalled cycles, where L is its 4-bit length field and a length of 0 counts as 1.
- R7: During a microcoded sequence, `in_ready` is 0 and `win_take` is 0 from the cycle after acceptance until the output shows the final sequencing cycle. `in_ready` returns to 1 in that final cycle.
- R8: While `stall` is 1, `in_ready` is 0 and `win_take` is 0, and after the next clock edge `slot_vld` and `uop_sum` are 0. A stalled cycle does not count toward a microcoded sequence.
- R9: For each valid slot, `slot_tag` holds the tag of the entry that slot took. During a microcoded sequence, slot 0 keeps that instruction's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Downstream stall; freezes allocation |
| win_vld | input | 3 | Valid bit per window entry, entry 0 oldest |
| win_cls | input | 6 | 2-bit uop class per entry |
| win_uops | input | 9 | 3-bit uop count field per entry (used by multi) |
| win_len | input | 12 | 4-bit microcode length per entry |
| win_tag | input | 18 | 6-bit tag per entry |
| in_ready | output | 1 | Block can take entries this cycle |
| win_take | output | 2 | Number of leading entries taken this cycle |
| slot_vld | output | 3 | Registered per-slot valid |
| slot_tag | output | 18 | Registered per-slot tag |
| uop_sum | output | 3 | Registered total uops emitted |

## Verification
The hardest case to reach is a stall that arrives partway through a microcoded sequence. Reaching it needs a long sequence already accepted and the stall raised on a chosen middle cycle. The test must then show that the sequence still produces its full count of valid cycles and ends without reopening the input early. The bench builds this case on purpose, and separately sweeps every valid mask against every combination of the three classes, using count fields that run past both ends of the multi range.

// File: rtl/dec_alloc_pkg.sv
`timescale 1ns/1ps
package dec_alloc_pkg;

    typedef enum logic [1:0] {
        CLS_SIMPLE = 2'b00,
        CLS_MULTI  = 2'b01,
        CLS_UCODE  = 2'b10,
        CLS_UCODE2 = 2'b11
    } uop_class_e;

    typedef enum logic {
        ST_GROUP = 1'b0,
        ST_UCODE = 1'b1
    } seq_state_e;

    localparam int CNT_W     = 3;
    localparam int MULTI_MIN = 2;
    localparam int MULTI_MAX = 4;

    function automatic logic [CNT_W-1:0] clamp_multi(input logic [CNT_W-1:0] f);
        if (int'(f) < MULTI_MIN)
            return CNT_W'(MULTI_MIN);
        else if (int'(f) > MULTI_MAX)
            return CNT_W'(MULTI_MAX);
        else
            return f;
    endfunction

endpackage

// File: rtl/dec_group_former.sv
`timescale 1ns/1ps
module dec_group_former
    import dec_alloc_pkg::*;
#(
    parameter int NSLOT   = 3,
    parameter int UC_UOPS = 4,
    parameter int TK_W    = 2,
    parameter int SUM_W   = 3
) (
    input  logic                   enable,
    input  logic [NSLOT-1:0]       win_vld,
    input  logic [2*NSLOT-1:0]     win_cls,
    input  logic [CNT_W*NSLOT-1:0] win_uops,
    output logic [NSLOT-1:0]       fill,
    output logic                   lead_ucode,
    output logic [TK_W-1:0]        take,
    output logic [SUM_W-1:0]       grp_sum
);

    uop_class_e       lead_cls;
    logic [CNT_W-1:0] lead_uops;

    assign lead_cls   = uop_class_e'(win_cls[1:0]);
    assign fill[0]    = enable & win_vld[0];
    assign lead_ucode = fill[0] & win_cls[1];

    // restricted slots: chain on the previous slot, simple class only
    for (genvar k = 1; k < NSLOT; k++) begin : g_restricted
        assign fill[k] = fill[k-1] & ~lead_ucode & win_vld[k]
                       & (uop_class_e'(win_cls[2*k +: 2]) == CLS_SIMPLE);
    end

    always_comb begin
        take = '0;
        for (int k = 0; k < NSLOT; k++) begin
            take = take + TK_W'(fill[k]);
        end
    end

    always_comb begin
        if (lead_cls == CLS_MULTI)
            lead_uops = clamp_multi(win_uops[CNT_W-1:0]);
        else
            lead_uops = CNT_W'(1);
    end

    always_comb begin
        grp_sum = '0;
        if (lead_ucode) begin
            grp_sum = SUM_W'(UC_UOPS);
        end else if (fill[0]) begin
            grp_sum = SUM_W'(lead_uops);
            for (int k = 1; k < NSLOT; k++) begin
                grp_sum = grp_sum + SUM_W'(fill[k]);
            end
        end
    end

endmodule

// File: rtl/dec_seq_fsm.sv
`timescale 1ns/1ps
module dec_seq_fsm
    import dec_alloc_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    output logic             busy
);

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] remain_q, remain_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_GROUP;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_GROUP: begin
                // GROUP_TO_UCODE when a long sequence is accepted
                if (!stall && start && (start_len > LEN_W'(1))) begin
                    state_d  = ST_UCODE;
                    remain_d = start_len - LEN_W'(1);
                end
            end
            ST_UCODE: begin
                if (!stall) begin
                    if (remain_q <= LEN_W'(1)) begin
                        state_d  = ST_GROUP;
                        remain_d = '0;
                    end else begin
                        remain_d = remain_q - LEN_W'(1);
                    end
                end
            end
            default: begin
                state_d  = ST_GROUP;
                remain_d = '0;
            end
        endcase
    end

    always_comb begin
        busy = (state_q == ST_UCODE);
    end

endmodule

// File: rtl/dec_out_stage.sv
`timescale 1ns/1ps
module dec_out_stage #(
    parameter int NSLOT   = 3,
    parameter int TAG_W   = 6,
    parameter int UC_UOPS = 4,
    parameter int SUM_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall,
    input  logic                   busy,
    input  logic [NSLOT-1:0]       fill,
    input  logic [TAG_W*NSLOT-1:0] win_tag,
    input  logic [SUM_W-1:0]       grp_sum,
    output logic [NSLOT-1:0]       slot_vld,
    output logic [TAG_W*NSLOT-1:0] slot_tag,
    output logic [SUM_W-1:0]       uop_sum
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_vld <= '0;
            uop_sum  <= '0;
        end else if (stall) begin
            slot_vld <= '0;
            uop_sum  <= '0;
        end else if (busy) begin
            slot_vld <= NSLOT'(1);
            uop_sum  <= SUM_W'(UC_UOPS);
        end else begin
            slot_vld <= fill;
            uop_sum  <= grp_sum;
        end
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_tag[TAG_W*k +: TAG_W] <= '0;
            else if (!stall && !busy && fill[k])
                slot_tag[TAG_W*k +: TAG_W] <= win_tag[TAG_W*k +: TAG_W];
        end
    end

endmodule

// File: rtl/dec_alloc3.sv
`timescale 1ns/1ps
module dec_alloc3
    import dec_alloc_pkg::*;
#(
    parameter  int NSLOT   = 3,
    parameter  int TAG_W   = 6,
    parameter  int LEN_W   = 4,
    parameter  int UC_UOPS = 4,
    localparam int GRPMAX  = MULTI_MAX + NSLOT - 1,
    localparam int MAXSUM  = (GRPMAX > UC_UOPS) ? GRPMAX : UC_UOPS,
    localparam int SUM_W   = $clog2(MAXSUM + 1),
    localparam int TK_W    = $clog2(NSLOT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall,
    input  logic [NSLOT-1:0]       win_vld,
    input  logic [2*NSLOT-1:0]     win_cls,
    input  logic [CNT_W*NSLOT-1:0] win_uops,
    input  logic [LEN_W*NSLOT-1:0] win_len,
    input  logic [TAG_W*NSLOT-1:0] win_tag,
    output logic                   in_ready,
    output logic [TK_W-1:0]        win_take,
    output logic [NSLOT-1:0]       slot_vld,
    output logic [TAG_W*NSLOT-1:0] slot_tag,
    output logic [SUM_W-1:0]       uop_sum
);

    logic             busy;
    logic [NSLOT-1:0] fill;
    logic             lead_ucode;
    logic [SUM_W-1:0] grp_sum;

    assign in_ready = ~stall & ~busy;

    dec_group_former #(
        .NSLOT  (NSLOT),
        .UC_UOPS(UC_UOPS),
        .TK_W   (TK_W),
        .SUM_W  (SUM_W)
    ) u_former (
        .enable    (in_ready),
        .win_vld   (win_vld),
        .win_cls   (win_cls),
        .win_uops  (win_uops),
        .fill      (fill),
        .lead_ucode(lead_ucode),
        .take      (win_take),
        .grp_sum   (grp_sum)
    );

    dec_seq_fsm #(
        .LEN_W(LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .start    (lead_ucode),
        .start_len(win_len[LEN_W-1:0]),
        .busy     (busy)
    );

    dec_out_stage #(
        .NSLOT  (NSLOT),
        .TAG_W  (TAG_W),
        .UC_UOPS(UC_UOPS),
        .SUM_W  (SUM_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .busy    (busy),
        .fill    (fill),
        .win_tag (win_tag),
        .grp_sum (grp_sum),
        .slot_vld(slot_vld),
        .slot_tag(slot_tag),
        .uop_sum (uop_sum)
    );

endmodule

// File: rtl/dec_alloc3_chk.sv
`timescale 1ns/1ps
module dec_alloc3_chk #(
    parameter int NSLOT   = 3,
    parameter int UC_UOPS = 4,
    parameter int TK_W    = 2,
    parameter int SUM_W   = 3,
    parameter int MAXSUM  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall,
    input logic [NSLOT-1:0]   win_vld,
    input logic [2*NSLOT-1:0] win_cls,
    input logic               in_ready,
    input logic [TK_W-1:0]    win_take,
    input logic [NSLOT-1:0]   slot_vld,
    input logic [SUM_W-1:0]   uop_sum
);

    // R4
    restricted_needs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_vld[NSLOT-1:1]) |-> slot_vld[0]);

    for (genvar k = 2; k < NSLOT; k++) begin : g_contig
        // R3
        contiguous_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[k] |-> slot_vld[k-1]);
    end

    // R3
    take_simple_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_take > TK_W'(1)) |-> (win_cls[3:2] == 2'b00));

    // R2
    lead_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && win_vld[0]) |-> (win_take != '0));

    // R5
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_sum <= SUM_W'(MAXSUM));

    // R6
    ucode_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && win_vld[0] && win_cls[1]) |-> (win_take == TK_W'(1)));

    // R6
    ucode_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && win_vld[0] && win_cls[1]) |=>
            (slot_vld == NSLOT'(1) && uop_sum == SUM_W'(UC_UOPS)));

    // R7
    take_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_take != '0) |-> in_ready);

    // R8
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!in_ready && win_take == '0));

    // R8
    stall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (slot_vld == '0 && uop_sum == '0));

endmodule

bind dec_alloc3 dec_alloc3_chk #(
    .NSLOT  (NSLOT),
    .UC_UOPS(UC_UOPS),
    .TK_W   (TK_W),
    .SUM_W  (SUM_W),
    .MAXSUM (MAXSUM)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .win_vld (win_vld),
    .win_cls (win_cls),
    .in_ready(in_ready),
    .win_take(win_take),
    .slot_vld(slot_vld),
    .uop_sum (uop_sum)
);

// File: tb/tb_dec_alloc3.sv
`timescale 1ns/1ps
module tb_dec_alloc3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [2:0]  win_vld = '0;
    logic [5:0]  win_cls = '0;
    logic [8:0]  win_uops = '0;
    logic [11:0] win_len = '0;
    logic [17:0] win_tag = '0;
    logic        in_ready;
    logic [1:0]  win_take;
    logic [2:0]  slot_vld;
    logic [17:0] slot_tag;
    logic [2:0]  uop_sum;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dec_alloc3 dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .win_vld (win_vld),
        .win_cls (win_cls),
        .win_uops(win_uops),
        .win_len (win_len),
        .win_tag (win_tag),
        .in_ready(in_ready),
        .win_take(win_take),
        .slot_vld(slot_vld),
        .slot_tag(slot_tag),
        .uop_sum (uop_sum)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampm(input int f);
        if (f < 2) return 2;
        if (f > 4) return 4;
        return f;
    endfunction

    // follow a microcoded instruction already shown for its first cycle
    task automatic follow_ucode(input int len, input int tag);
        for (int j = 1; j < len; j++) begin
            @(negedge clk);
            win_vld = '0;
            #1;
            chk("R7 ready low in sequence", int'(in_ready), 0);
            chk("R7 take zero in sequence", int'(win_take), 0);
            @(posedge clk);
            #1;
            chk("R6 sequence slot_vld", int'(slot_vld), 1);
            chk("R6 sequence uop_sum", int'(uop_sum), 4);
            chk("R9 sequence tag held", int'(slot_tag[5:0]), tag);
        end
        chk("R7 ready back on final cycle", int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset slot_vld", int'(slot_vld), 0);
        chk("R1 reset uop_sum", int'(uop_sum), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 ready after reset", int'(in_ready), 1);

        // sweep: every valid mask against every class triple
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 27; c++) begin
                int d[3];
                int f[3];
                int t[3];
                int p;
                int len0;
                int e_take;
                int e_sum;
                int e_vld;
                logic ucode0;
                d[0] = c % 3;
                d[1] = (c / 3) % 3;
                d[2] = c / 9;
                @(negedge clk);
                for (int k = 0; k < 3; k++) begin
                    f[k] = (c + m + k * 3) % 8;
                    t[k] = (c * 3 + m * 7 + k) % 64;
                    win_cls[2*k +: 2] = (d[k] == 0) ? 2'b00 :
                                        (d[k] == 1) ? 2'b01 :
                                        ((m % 2) == 1 ? 2'b11 : 2'b10);
                    win_uops[3*k +: 3] = 3'(f[k]);
                    win_tag[6*k +: 6]  = 6'(t[k]);
                end
                len0 = (c + m) % 5;
                win_len = {4'd3, 4'd7, 4'(len0)};
                win_vld = 3'(m);
                p = 0;
                while (p < 3 && m[p]) p++;
                ucode0 = (p >= 1) && (d[0] == 2);
                e_take = 0;
                e_sum = 0;
                e_vld = 0;
                if (p >= 1) begin
                    e_take = 1;
                    e_vld = 1;
                    if (ucode0) begin
                        e_sum = 4;
                    end else begin
                        e_sum = (d[0] == 1) ? clampm(f[0]) : 1;
                        if (p >= 2 && d[1] == 0) begin
                            e_take = 2; e_vld = 3; e_sum++;
                            if (p >= 3 && d[2] == 0) begin
                                e_take = 3; e_vld = 7; e_sum++;
                            end
                        end
                    end
                end
                #1;
                chk("R7 ready in group state", int'(in_ready), 1);
                chk(p == 0 ? "R4 take without lead" : "R3 take count",
                    int'(win_take), e_take);
                @(posedge clk);
                #1;
                chk(p == 0 ? "R4 slot_vld without lead" : "R3 slot_vld",
                    int'(slot_vld), e_vld);
                chk(ucode0 ? "R6 uop_sum" : "R5 uop_sum", int'(uop_sum), e_sum);
                for (int k = 0; k < 3; k++) begin
                    if (e_vld[k]) chk("R9 slot tag", int'(slot_tag[6*k +: 6]), t[k]);
                end
                if (p >= 1) chk("R2 lead taken", int'(slot_vld[0]), 1);
                if (ucode0) follow_ucode((len0 == 0) ? 1 : len0, t[0]);
            end
        end

        // stall with a full simple window, then release
        @(negedge clk);
        win_vld = 3'b111;
        win_cls = 6'b000000;
        win_tag = {6'd33, 6'd22, 6'd11};
        stall = 1'b1;
        #1;
        chk("R8 ready under stall", int'(in_ready), 0);
        chk("R8 take under stall", int'(win_take), 0);
        @(posedge clk);
        #1;
        chk("R8 outputs cleared", int'(slot_vld), 0);
        chk("R8 sum cleared", int'(uop_sum), 0);
        @(negedge clk);
        stall = 1'b0;
        #1;
        chk("R8 take after release", int'(win_take), 3);
        @(posedge clk);
        #1;
        chk("R5 three simple sum", int'(uop_sum), 3);

        // stall in the middle of a length-4 microcoded sequence
        @(negedge clk);
        win_vld = 3'b111;
        win_cls = 6'b000010;
        win_len = {4'd1, 4'd1, 4'd4};
        win_tag = {6'd3, 6'd2, 6'd45};
        #1;
        chk("R6 ucode taken alone", int'(win_take), 1);
        @(posedge clk);
        #1;
        chk("R6 ucode cycle 1", int'(slot_vld), 1);
        @(negedge clk);
        win_vld = '0;
        stall = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 stall mid sequence clears", int'(slot_vld), 0);
        @(negedge clk);
        stall = 1'b0;
        #1;
        chk("R7 still busy after stall", int'(in_ready), 0);
        for (int j = 2; j <= 4; j++) begin
            @(posedge clk);
            #1;
            chk("R8 sequence resumes", int'(slot_vld), 1);
            chk("R9 tag after stall", int'(slot_tag[5:0]), 45);
            if (j < 4) begin
                @(negedge clk);
                #1;
                chk("R7 ready low mid sequence", int'(in_ready), j == 3 ? 0 : 0);
            end
        end
        chk("R7 ready back after stalled sequence", int'(in_ready), 1);
        @(negedge clk);
        @(posedge clk);
        #1;
        chk("R6 sequence ended at full length", int'(slot_vld), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule